// File: doc/BRIEF.md
# Sequenced Clear-on-Read Packet Statistics

This block counts transmitted and received packets and packet errors, and presents them through a 16-bit read port. Each direction owns a 32-bit good-packet counter and a 16-bit error counter. These are seen as a group of three adjacent registers: the low half of the packet count, the high half, then the error count. A separate register carries a 6-bit count of link-loss events in its top six bits.

Reading a group is a transaction. The first register of a group freezes that group, so the three reads form one consistent snapshot even when the halves of the 32-bit count are read in separate cycles. Events that arrive while the group is frozen go into a shadow accumulator. The group is cleared only when its three registers are read back to back in their natural order. Reads elsewhere may come between them. Clearing loads the shadow value as the new count. An access out of order ends the freeze without a clear and folds the shadow back into the live count, so no event is ever dropped.

A poller reads the six statistics registers in order at whatever rate it likes. Each pass returns the increments since the previous completed pass.

Top module: `seq_stat_counters`

## Requirements
- R1: After reset every counter reads zero and the read data output is zero.
- R2: Each cycle with an event pulse high adds one to the matching counter. The transmit group sits at addresses 0x639 (packet count bits [15:0]), 0x63A (bits [31:16]) and 0x63B (error count). The receive group sits at 0x63C, 0x63D and 0x63E with the same layout.
- R3: The packet counters stop at all-ones (32 bits), the error counters stop at all-ones (16 bits) and the link-loss counter stops at 63, with no wrap.
- R4: A read of address 0x547 returns the link-loss count in bits [15:10] with zeros below. Reading it does not clear it.
- R5: Read data is registered. It appears on the clock edge that samples the read strobe and holds its value in every cycle without a strobe.
- R6: A read of a group's first register freezes the group. Later reads of the group return the counts as they stood before that first read's cycle. An event in the same cycle as that read is not part of the snapshot.
- R7: A read of the second register and then the third, following the first, clears the group. Afterwards the group holds exactly the events that arrived while it was frozen, including those in the cycle of the third read.
- R8: A read of a group register other than the next one expected ends the freeze without clearing, and the group then holds the total of all its events. A read of the second or third register while the group is not frozen neither freezes nor clears it.
- R9: A read of an address outside a group leaves that group's sequence untouched. This covers the other group, the link-loss register and unmapped addresses. An unmapped address reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_pkt_i | input | 1 | Transmit good-packet event pulse |
| tx_err_i | input | 1 | Transmit error-packet event pulse |
| rx_pkt_i | input | 1 | Receive good-packet event pulse |
| rx_err_i | input | 1 | Receive error-packet event pulse |
| link_loss_i | input | 1 | Link-loss event pulse |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 11 | Read address |
| rd_data_o | output | 16 | Registered read data |

## Verification
The checker watches the read port on every cycle. It checks that:
- the data is zero just after reset;
- the data holds when there is no strobe;
- unmapped addresses return zero;
- the bits below the link-loss field stay zero.

Freezing, the shadow accumulator, clearing after the exact in-order sequence, and merging after an out-of-order read all depend on event history across several reads. Only the bench's scenarios show these behaviours, by comparing read values against event counts they drove. Saturation is shown by a long run of back-to-back events.

// File: rtl/seq_stat_pkg.sv
// Shared types for the sequenced statistics block.
// Assumes a group is always three registers wide.
package seq_stat_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE      = 2'd0,
        SEQ_WANT_MID  = 2'd1,
        SEQ_WANT_LAST = 2'd2
    } seq_state_e;

    localparam int GROUP_REGS = 3;
endpackage

// File: rtl/seq_stat_lane.sv
// One saturating counter with a shadow accumulator.
// While hold_i is high, events go to the shadow and the live value stays put.
// clr_i loads the shadow as the new live count. mrg_i adds the shadow into live.
// Assumes clr_i and mrg_i are never high together.
module seq_stat_lane #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ev_i,
    input  logic         hold_i,
    input  logic         clr_i,
    input  logic         mrg_i,
    output logic [W-1:0] live_o
);
    localparam logic [W-1:0] MAXV = '1;

    logic [W-1:0] live_q;
    logic [W-1:0] shad_q;

    // Saturating three-term add.
    function automatic logic [W-1:0] sat_add(input logic [W-1:0] a,
                                              input logic [W-1:0] b,
                                              input logic c);
        logic [W+1:0] s;
        s = {2'b00, a} + {2'b00, b} + {{(W+1){1'b0}}, c};
        return (s > {2'b00, MAXV}) ? MAXV : s[W-1:0];
    endfunction

    // Update the live count and the shadow count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
            shad_q <= '0;
        end else if (clr_i) begin
            live_q <= sat_add(shad_q, '0, ev_i);
            shad_q <= '0;
        end else if (mrg_i) begin
            live_q <= sat_add(live_q, shad_q, ev_i);
            shad_q <= '0;
        end else if (hold_i) begin
            shad_q <= sat_add(shad_q, '0, ev_i);
        end else begin
            live_q <= sat_add(live_q, '0, ev_i);
        end
    end

    assign live_o = live_q;
endmodule

// File: rtl/seq_stat_group.sv
// One direction: a packet counter twice the data width and an error counter
// one data width wide, shown as three registers (index 0, 1, 2).
// Tracks the read sequence and drives the freeze, clear and merge of both lanes.
// Assumes acc_i is high only for indexes 0..2.
module seq_stat_group
    import seq_stat_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_ev_i,
    input  logic              err_ev_i,
    input  logic              acc_i,
    input  logic [1:0]        idx_i,
    output logic [DATA_W-1:0] data_o
);
    localparam int PKT_W = 2 * DATA_W;
    localparam int ERR_W = DATA_W;

    seq_state_e state_q, state_d;
    logic start, clr, mrg, hold;
    logic [PKT_W-1:0] pkt_cnt;
    logic [ERR_W-1:0] err_cnt;

    // Next sequence state and the lane controls.
    always_comb begin
        state_d = state_q;
        start   = 1'b0;
        clr     = 1'b0;
        mrg     = 1'b0;
        if (acc_i) begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (idx_i == 2'd0) begin
                        start   = 1'b1;
                        state_d = SEQ_WANT_MID;
                    end
                end
                SEQ_WANT_MID: begin
                    if (idx_i == 2'd1) begin
                        state_d = SEQ_WANT_LAST;
                    end else begin
                        mrg     = 1'b1;
                        state_d = SEQ_IDLE;
                    end
                end
                SEQ_WANT_LAST: begin
                    if (idx_i == 2'd2) clr = 1'b1;
                    else               mrg = 1'b1;
                    state_d = SEQ_IDLE;
                end
                default: state_d = SEQ_IDLE;
            endcase
        end
    end

    // Sequence state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    assign hold = (state_q != SEQ_IDLE) || start;

    seq_stat_lane #(.W(PKT_W)) u_pkt (
        .clk(clk), .rst_n(rst_n), .ev_i(pkt_ev_i), .hold_i(hold),
        .clr_i(clr), .mrg_i(mrg), .live_o(pkt_cnt)
    );

    seq_stat_lane #(.W(ERR_W)) u_err (
        .clk(clk), .rst_n(rst_n), .ev_i(err_ev_i), .hold_i(hold),
        .clr_i(clr), .mrg_i(mrg), .live_o(err_cnt)
    );

    // Select the register addressed by idx_i.
    always_comb begin
        unique case (idx_i)
            2'd0:    data_o = pkt_cnt[DATA_W-1:0];
            2'd1:    data_o = pkt_cnt[PKT_W-1:DATA_W];
            2'd2:    data_o = err_cnt;
            default: data_o = '0;
        endcase
    end
endmodule

// File: rtl/seq_stat_counters.sv
// Top of the sequenced statistics block: a transmit group, a receive group at
// the next three addresses, a saturating link-loss counter, and a registered
// read port. Assumes single-cycle event pulses, at most one event per source
// per cycle.
module seq_stat_counters #(
    parameter int                    DATA_W    = 16,
    parameter int                    ADDR_W    = 11,
    parameter int                    LINK_W    = 6,
    parameter logic [ADDR_W-1:0]     TX_BASE   = 11'h639,
    parameter logic [ADDR_W-1:0]     LINK_ADDR = 11'h547
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_pkt_i,
    input  logic              tx_err_i,
    input  logic              rx_pkt_i,
    input  logic              rx_err_i,
    input  logic              link_loss_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);
    import seq_stat_pkg::*;

    localparam int NUM_GRP  = 2;
    localparam int LINK_LSB = DATA_W - LINK_W;

    logic [NUM_GRP-1:0]  pkt_ev, err_ev, grp_hit;
    logic [DATA_W-1:0]   grp_data [NUM_GRP];
    logic [LINK_W-1:0]   link_q;
    logic [DATA_W-1:0]   rd_mux;

    assign pkt_ev = {rx_pkt_i, tx_pkt_i};
    assign err_ev = {rx_err_i, tx_err_i};

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam logic [ADDR_W-1:0] GBASE = TX_BASE + ADDR_W'(GROUP_REGS * g);
        logic [ADDR_W-1:0] off;

        assign off        = rd_addr_i - GBASE;
        assign grp_hit[g] = (rd_addr_i >= GBASE) &&
                            (rd_addr_i < GBASE + ADDR_W'(GROUP_REGS));

        seq_stat_group #(.DATA_W(DATA_W)) u_grp (
            .clk(clk), .rst_n(rst_n),
            .pkt_ev_i(pkt_ev[g]), .err_ev_i(err_ev[g]),
            .acc_i(rd_en_i && grp_hit[g]), .idx_i(off[1:0]),
            .data_o(grp_data[g])
        );
    end

    // Saturating link-loss counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                               link_q <= '0;
        else if (link_loss_i && (link_q != '1))   link_q <= link_q + 1'b1;
    end

    // Address decode for the read port.
    always_comb begin
        if (grp_hit[0])                  rd_mux = grp_data[0];
        else if (grp_hit[1])             rd_mux = grp_data[1];
        else if (rd_addr_i == LINK_ADDR) rd_mux = {link_q, {LINK_LSB{1'b0}}};
        else                             rd_mux = '0;
    end

    // Register read data on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_data_o <= '0;
        else if (rd_en_i) rd_data_o <= rd_mux;
    end
endmodule

// File: rtl/seq_stat_counters_chk.sv
// Port-level checker for seq_stat_counters, attached with bind.
module seq_stat_counters_chk #(
    parameter int                DATA_W    = 16,
    parameter int                ADDR_W    = 11,
    parameter int                LINK_W    = 6,
    parameter logic [ADDR_W-1:0] TX_BASE   = 11'h639,
    parameter logic [ADDR_W-1:0] LINK_ADDR = 11'h547
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data
);
    localparam int LINK_LSB = DATA_W - LINK_W;

    logic mapped;
    assign mapped = ((rd_addr >= TX_BASE) && (rd_addr < TX_BASE + ADDR_W'(6))) ||
                    (rd_addr == LINK_ADDR);

    // R1: the port leaves reset at zero.
    p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> rd_data == '0);

    // R5: no strobe, no change.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> $stable(rd_data));

    // R9: unmapped addresses read as zero.
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && !mapped) |-> rd_data == '0);

    // R4: only the top field of the link register carries data.
    p_link_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && rd_addr == LINK_ADDR) |-> rd_data[LINK_LSB-1:0] == '0);
endmodule

bind seq_stat_counters seq_stat_counters_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LINK_W(LINK_W),
    .TX_BASE(TX_BASE), .LINK_ADDR(LINK_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en_i),
    .rd_addr(rd_addr_i), .rd_data(rd_data_o)
);

// File: tb/seq_stat_counters_tb.sv
module seq_stat_counters_tb;
    localparam logic [10:0] A_TX0 = 11'h639, A_TX1 = 11'h63A, A_TX2 = 11'h63B;
    localparam logic [10:0] A_RX0 = 11'h63C, A_RX1 = 11'h63D, A_RX2 = 11'h63E;
    localparam logic [10:0] A_LNK = 11'h547, A_NONE = 11'h000;
    localparam logic [4:0] E_NONE = 5'd0, E_TXP = 5'd1, E_TXE = 5'd2,
                           E_RXP = 5'd4, E_RXE = 5'd8, E_LNK = 5'd16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  ev = '0;
    logic        rd_en = 1'b0;
    logic [10:0] rd_addr = '0;
    logic [15:0] rd_data;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    seq_stat_counters u_dut (
        .clk(clk), .rst_n(rst_n),
        .tx_pkt_i(ev[0]), .tx_err_i(ev[1]), .rx_pkt_i(ev[2]),
        .rx_err_i(ev[3]), .link_loss_i(ev[4]),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
        end
    endtask

    // One read with optional same-cycle events; data sampled one edge later.
    task automatic rd(input string tag, input logic [10:0] a, input logic [4:0] e,
                      input logic [15:0] exp);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a; ev = e;
        @(negedge clk);
        rd_en = 1'b0; ev = E_NONE;
        check(tag, rd_data, exp);
    endtask

    task automatic pulse(input logic [4:0] e, input int n);
        @(negedge clk);
        ev = e;
        repeat (n) @(negedge clk);
        ev = E_NONE;
    endtask

    task automatic t_reset;
        check("R1 port after reset", rd_data, 16'h0);
        rd("R1 tx lo", A_TX0, E_NONE, 16'h0);
        rd("R1 tx hi", A_TX1, E_NONE, 16'h0);
        rd("R1 tx err", A_TX2, E_NONE, 16'h0);
        rd("R1 rx lo", A_RX0, E_NONE, 16'h0);
        rd("R1 rx hi", A_RX1, E_NONE, 16'h0);
        rd("R1 rx err", A_RX2, E_NONE, 16'h0);
        rd("R1 link", A_LNK, E_NONE, 16'h0);
    endtask

    task automatic t_count;
        pulse(E_TXP, 5); pulse(E_TXE, 2); pulse(E_RXP, 3); pulse(E_RXE, 1);
        rd("R2 tx lo", A_TX0, E_NONE, 16'd5);
        rd("R2 tx hi", A_TX1, E_NONE, 16'd0);
        rd("R2 tx err", A_TX2, E_NONE, 16'd2);
        rd("R2 rx lo", A_RX0, E_NONE, 16'd3);
        rd("R2 rx hi", A_RX1, E_NONE, 16'd0);
        rd("R2 rx err", A_RX2, E_NONE, 16'd1);
        rd("R7 tx cleared lo", A_TX0, E_NONE, 16'd0);
        rd("R7 tx cleared hi", A_TX1, E_NONE, 16'd0);
        rd("R7 tx cleared err", A_TX2, E_NONE, 16'd0);
        rd("R7 rx cleared lo", A_RX0, E_NONE, 16'd0);
        rd("R7 rx cleared hi", A_RX1, E_NONE, 16'd0);
        rd("R7 rx cleared err", A_RX2, E_NONE, 16'd0);
    endtask

    task automatic t_freeze;
        pulse(E_TXP, 6);
        rd("R6 snapshot excludes same-cycle event", A_TX0, E_TXP, 16'd6);
        pulse(E_TXP, 3); pulse(E_TXE, 2);
        rd("R6 frozen hi", A_TX1, E_NONE, 16'd0);
        rd("R6 frozen err", A_TX2, E_TXP, 16'd0);
        rd("R7 shadow lo", A_TX0, E_NONE, 16'd5);
        rd("R7 shadow hi", A_TX1, E_NONE, 16'd0);
        rd("R7 shadow err", A_TX2, E_NONE, 16'd2);
    endtask

    task automatic t_out_of_order;
        pulse(E_TXP, 3);
        rd("R8 first", A_TX0, E_NONE, 16'd3);
        pulse(E_TXP, 2);
        rd("R8 second", A_TX1, E_NONE, 16'd0);
        rd("R8 repeat first", A_TX0, E_NONE, 16'd3);
        rd("R8 idle second", A_TX1, E_NONE, 16'd0);
        pulse(E_TXP, 1);
        rd("R8 idle third", A_TX2, E_NONE, 16'd0);
        rd("R8 merged lo", A_TX0, E_NONE, 16'd6);
        rd("R8 merged hi", A_TX1, E_NONE, 16'd0);
        rd("R8 merged err", A_TX2, E_NONE, 16'd0);
        rd("R8 cleared after good pass", A_TX0, E_NONE, 16'd0);
        rd("R8 cleared hi", A_TX1, E_NONE, 16'd0);
        rd("R8 cleared err", A_TX2, E_NONE, 16'd0);
    endtask

    task automatic t_interleave;
        pulse(E_TXP, 4); pulse(E_RXP, 2);
        rd("R9 tx first", A_TX0, E_NONE, 16'd4);
        rd("R9 unmapped zero", A_NONE, E_NONE, 16'd0);
        rd("R9 rx first", A_RX0, E_NONE, 16'd2);
        rd("R9 link between", A_LNK, E_NONE, 16'd0);
        rd("R9 tx second", A_TX1, E_NONE, 16'd0);
        rd("R9 tx third", A_TX2, E_NONE, 16'd0);
        rd("R9 rx second", A_RX1, E_NONE, 16'd0);
        rd("R9 rx third", A_RX2, E_NONE, 16'd0);
        rd("R9 tx cleared", A_TX0, E_NONE, 16'd0);
        rd("R9 tx hi", A_TX1, E_NONE, 16'd0);
        rd("R9 tx err", A_TX2, E_NONE, 16'd0);
        rd("R9 rx cleared", A_RX0, E_NONE, 16'd0);
        rd("R9 rx hi", A_RX1, E_NONE, 16'd0);
        rd("R9 rx err", A_RX2, E_NONE, 16'd0);
    endtask

    task automatic t_link_hold;
        pulse(E_LNK, 3);
        rd("R4 link field", A_LNK, E_NONE, 16'h0C00);
        rd("R4 link not cleared", A_LNK, E_NONE, 16'h0C00);
        pulse(E_TXP, 2);
        repeat (3) @(negedge clk);
        check("R5 data held without strobe", rd_data, 16'h0C00);
        rd("R5 tx lo", A_TX0, E_NONE, 16'd2);
        rd("R5 tx hi", A_TX1, E_NONE, 16'd0);
        rd("R5 tx err", A_TX2, E_NONE, 16'd0);
    endtask

    task automatic t_saturate;
        pulse(E_RXP | E_RXE | E_LNK, 70000);
        rd("R3 rx lo", A_RX0, E_NONE, 16'd4464);
        rd("R3 rx hi", A_RX1, E_NONE, 16'd1);
        rd("R3 rx err saturated", A_RX2, E_NONE, 16'hFFFF);
        rd("R3 link saturated", A_LNK, E_NONE, 16'hFC00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_freeze();
        t_out_of_order();
        t_interleave();
        t_link_hold();
        t_saturate();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule